// File: doc/BRIEF.md
# Byte-Lane Register Map Bus Slave

This block is the processor-facing register file of a display controller. It sits on a 16-bit asynchronous bus with separate strobes, in the style of classic 16-bit microprocessors. Register data always travels on the upper byte of the data bus. The register index travels on the lower byte of the same bus. Because of this split, a single 16-bit word write carries both the index and the value. A processor that only ever writes can program any register with one bus cycle.

The three bus control inputs are a register-select strobe, an upper-byte strobe and a read/write line. Each is brought into the block clock through a two-stage synchroniser. An access is decoded one cycle after both strobes are seen active. A write commits the upper byte into the selected register. A read captures the selected register into an output holding register. The block then asserts an active-low transfer acknowledge and holds it until either strobe is released. The upper byte is handed to the pad only while an acknowledged read is in progress and both raw strobes are still low.

The array spans a 64-entry index space from bits 5:0 of the lower byte. Only the first 48 entries are implemented.

Top module: `regmap_bus_slave`

## Requirements
- R1: A write stores `bus_hi_i` into the register whose index is `bus_lo[5:0]`. Bits 7:6 of `bus_lo` do not take part in the index.
- R2: A read presents the contents of register `bus_lo[5:0]` on `bus_hi_o` while `bus_hi_oe` is high.
- R3: No access takes place unless `sel_n` and `uds_n` are both low. A strobe pattern with either one high neither changes a register nor asserts `dtack_n`.
- R4: The inputs pass through a two-flop synchroniser. When both strobes fall together just before a clock edge, `dtack_n` goes low in the fourth cycle after that edge.
- R5: `dtack_n` is active low. It falls only in the cycle after a write has committed or read data has been captured. It stays low while both strobes remain low, and it returns high within one clock once the synchronised strobes show a release.
- R6: `bus_hi_oe` is high only during an acknowledged read while the raw `sel_n` and `uds_n` are both low. During writes and idle periods it is low.
- R7: Indices 48 to 63 are unimplemented. A read of one returns 0x00. A write to one is acknowledged but leaves every register unchanged.
- R8: After reset every register reads 0x00, `dtack_n` is high and `bus_hi_oe` is low.
- R9: If the strobes are released before the access is decoded, the access is abandoned. No register changes and `dtack_n` stays high.
- R10: A single 16-bit word write (upper byte = value, lower byte = index) programs that register in one bus cycle.
- R11: Accesses may follow one another back to back. A new access starts as soon as the previous acknowledge has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Register-map select strobe, active low, asynchronous |
| uds_n | input | 1 | Upper data strobe, active low, asynchronous |
| rd_wr | input | 1 | Direction: 1 = read, 0 = write |
| bus_lo | input | 8 | Lower data byte, carries the register index |
| bus_hi_i | input | 8 | Upper data byte as seen from the bus |
| bus_hi_o | output | 8 | Upper data byte driven on a read |
| bus_hi_oe | output | 1 | Upper-byte pad enable; low means high impedance |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The bench first runs a sweep of back-to-back writes over every implemented index, each with a distinct value. A full read-back follows. This separates index decoding errors from data-lane errors. Further words set the ignored index bits, target unimplemented indices, or arrive as one combined word. These show whether aliasing, discard and the write-only path behave as specified.

Other patterns drive incomplete strobe pairs and a one-cycle strobe pulse that is released before decoding. Both must leave the registers untouched and produce no acknowledge. A behavioural model checks acknowledge timing and pad enable on every cycle, so latency and release errors show up apart from data errors.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

  localparam int LANE_W   = 8;
  localparam int IDX_W    = 6;
  localparam int NUM_REGS = 48;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DECODE = 2'd1,
    PH_ACK    = 2'd2
  } phase_e;

  // Register index carried in the low lane.
  function automatic logic [IDX_W-1:0] lane_index(input logic [LANE_W-1:0] lo);
    return lo[IDX_W-1:0];
  endfunction

  // True when an index falls inside the implemented part of the map.
  function automatic logic idx_present(input logic [IDX_W-1:0] idx, input int nregs);
    return int'(idx) < nregs;
  endfunction

endpackage

// File: rtl/regmap_sync.sv
module regmap_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/regmap_array.sv
module regmap_array
  import regmap_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int IW    = IDX_W,
  parameter int DW    = LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] regs_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREGS; k++) regs_q[k] <= '0;
    end else begin
      for (int k = 0; k < NREGS; k++) begin
        if (wr_en && wr_idx == IW'(k)) regs_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NREGS; k++) begin
      if (rd_idx == IW'(k)) rd_data = regs_q[k];
    end
  end

  generate
    for (genvar k = 0; k < NREGS; k++) begin : g_chk
      AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IW'(k)) |=> (regs_q[k] == $past(wr_data))); // R1
    end
  endgenerate

endmodule

// File: rtl/regmap_ctrl.sv
module regmap_ctrl
  import regmap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_sel_n,
  input  logic s_uds_n,
  input  logic s_rd,
  output logic commit,
  output logic wr_en,
  output logic rd_cap,
  output logic rd_phase,
  output logic dtack_n
);

  phase_e ph_q, ph_d;
  logic   rd_q;
  logic   strobes_on;

  assign strobes_on = !s_sel_n && !s_uds_n;
  assign commit     = (ph_q == PH_DECODE) && strobes_on;
  assign wr_en      = commit && !s_rd;
  assign rd_cap     = commit && s_rd;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:   if (strobes_on) ph_d = PH_DECODE;
      PH_DECODE: ph_d = commit ? PH_ACK : PH_IDLE;
      PH_ACK:    if (!strobes_on) ph_d = PH_IDLE;
      default:   ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      rd_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (commit) rd_q <= s_rd;
    end
  end

  assign dtack_n  = (ph_q != PH_ACK);
  assign rd_phase = (ph_q == PH_ACK) && rd_q;

  AST_ACK_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> $past(commit)); // R5
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !strobes_on) |=> dtack_n); // R5
  AST_ABORT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DECODE && !strobes_on) |=> dtack_n); // R9

endmodule

// File: rtl/regmap_bus_slave.sv
module regmap_bus_slave
  import regmap_pkg::*;
#(
  parameter int NREGS = NUM_REGS,
  parameter int IW    = IDX_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       uds_n,
  input  logic       rd_wr,
  input  logic [7:0] bus_lo,
  input  logic [7:0] bus_hi_i,
  output logic [7:0] bus_hi_o,
  output logic       bus_hi_oe,
  output logic       dtack_n
);

  localparam int SYNC_STAGES = 2;

  logic [2:0]    ctl_sync;
  logic          s_sel_n, s_uds_n, s_rd;
  logic          commit, wr_en, rd_cap, rd_phase;
  logic [IW-1:0] acc_idx;
  logic [7:0]    arr_rd;
  logic [7:0]    rdata_q;

  regmap_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sel_n, uds_n, rd_wr}),
    .q     (ctl_sync)
  );

  assign s_sel_n = ctl_sync[2];
  assign s_uds_n = ctl_sync[1];
  assign s_rd    = ctl_sync[0];

  regmap_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_sel_n  (s_sel_n),
    .s_uds_n  (s_uds_n),
    .s_rd     (s_rd),
    .commit   (commit),
    .wr_en    (wr_en),
    .rd_cap   (rd_cap),
    .rd_phase (rd_phase),
    .dtack_n  (dtack_n)
  );

  assign acc_idx = IW'(lane_index(bus_lo));

  generate
    if (IW < 8) begin : g_unused_idx
      logic unused_idx_bits;
      assign unused_idx_bits = ^bus_lo[7:IW];
    end
  endgenerate

  regmap_array #(.NREGS(NREGS), .IW(IW), .DW(8)) i_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (acc_idx),
    .wr_data (bus_hi_i),
    .rd_idx  (acc_idx),
    .rd_data (arr_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_cap) rdata_q <= idx_present(acc_idx, NREGS) ? arr_rd : 8'h00;
  end

  assign bus_hi_o  = rdata_q;
  assign bus_hi_oe = rd_phase && !sel_n && !uds_n;

  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!s_sel_n && !s_uds_n && !s_rd)); // R3
  AST_DRIVE_ONLY_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hi_oe |-> !dtack_n); // R6
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !$past(s_rd)) |-> !bus_hi_oe); // R6

endmodule

// File: tb/test_regmap_bus_slave.sv
module test_regmap_bus_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, uds_n = 1'b1, rd_wr = 1'b0;
  logic [7:0] bus_lo = 8'h00, bus_hi_i = 8'h00;
  logic [7:0] bus_hi_o;
  logic       bus_hi_oe, dtack_n;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  regmap_bus_slave i_regmap_bus_slave (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .uds_n(uds_n), .rd_wr(rd_wr),
    .bus_lo(bus_lo), .bus_hi_i(bus_hi_i), .bus_hi_o(bus_hi_o),
    .bus_hi_oe(bus_hi_oe), .dtack_n(dtack_n)
  );

  // Behavioural reference: two delayed copies of the strobe state, a phase
  // number and a memory of integers.
  int mem[64];
  bit m_on1, m_on2, m_rd1, m_rd2, m_rdl;
  int m_ph, m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] = 0;
      m_on1 = 0; m_on2 = 0; m_rd1 = 0; m_rd2 = 0; m_rdl = 0; m_ph = 0; m_rdata = 0;
    end else begin
      int idx;
      idx = bus_lo % 64;
      case (m_ph)
        0: if (m_on2) m_ph = 1;
        1: if (m_on2) begin
             if (!m_rd2) begin if (idx < 48) mem[idx] = bus_hi_i; end
             else m_rdata = (idx < 48) ? mem[idx] : 0;
             m_rdl = m_rd2;
             m_ph  = 2;
           end else m_ph = 0;
        default: if (!m_on2) m_ph = 0;
      endcase
      m_on2 = m_on1; m_rd2 = m_rd1;
      m_on1 = !sel_n && !uds_n; m_rd1 = rd_wr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison with the model, away from the rising edge.
  task automatic step();
    bit e_dt, e_oe;
    @(negedge clk);
    e_dt = (m_ph != 2);
    e_oe = (m_ph == 2) && m_rdl && !sel_n && !uds_n;
    chk(dtack_n === e_dt, "R5 dtack_n", dtack_n, e_dt);
    chk(bus_hi_oe === e_oe, "R6 bus_hi_oe", bus_hi_oe, e_oe);
    if (e_oe) chk(bus_hi_o === m_rdata[7:0], "R2 bus_hi_o", bus_hi_o, m_rdata);
  endtask

  task automatic access(input bit rd, input logic [7:0] lo, input logic [7:0] hi,
                        output logic [7:0] got, output int lat, output bit oe_seen);
    sel_n = 0; uds_n = 0; rd_wr = rd; bus_lo = lo; bus_hi_i = hi;
    lat = 0;
    do begin step(); lat++; end while (dtack_n && lat < 20);
    got = bus_hi_o; oe_seen = bus_hi_oe;
    sel_n = 1; uds_n = 1;
    for (int g = 0; g < 10; g++) begin step(); if (dtack_n) break; end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) ^ 8'h5A);
  endfunction

  logic [7:0] got;
  int lat;
  bit oe_seen, ack_seen;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk(dtack_n === 1'b1, "R8 dtack after reset", dtack_n, 1);
    chk(bus_hi_oe === 1'b0, "R8 oe after reset", bus_hi_oe, 0);
    access(1, 8'd0, 8'h00, got, lat, oe_seen);
    chk(got === 8'h00, "R8 reg0 reset", got, 0);
    access(1, 8'd47, 8'h00, got, lat, oe_seen);
    chk(got === 8'h00, "R8 reg47 reset", got, 0);

    // R11 back-to-back writes over all implemented indices
    for (int k = 0; k < 48; k++) begin
      access(0, 8'(k), pat(k), got, lat, oe_seen);
      if (k == 0) chk(lat == 4, "R4 latency", lat, 4);
      if (k == 1) chk(oe_seen == 1'b0, "R6 no drive on write", oe_seen, 0);
    end
    for (int k = 0; k < 48; k++) begin
      access(1, 8'(k), 8'h00, got, lat, oe_seen);
      chk(got === pat(k), "R1 R2 R11 readback", got, pat(k));
    end

    // R1 index bits 7:6 ignored
    access(0, 8'hC5, 8'hA5, got, lat, oe_seen);
    access(1, 8'h05, 8'h00, got, lat, oe_seen);
    chk(got === 8'hA5, "R1 alias", got, 8'hA5);

    // R7 unimplemented index
    access(0, 8'd50, 8'h77, got, lat, oe_seen);
    chk(lat < 20, "R7 write acked", lat, 4);
    access(1, 8'd50, 8'h00, got, lat, oe_seen);
    chk(got === 8'h00, "R7 read zero", got, 0);
    access(1, 8'd18, 8'h00, got, lat, oe_seen);
    chk(got === pat(18), "R7 neighbour intact", got, pat(18));

    // R3 one strobe only
    ack_seen = 0;
    sel_n = 0; uds_n = 1; rd_wr = 0; bus_lo = 8'd3; bus_hi_i = 8'hEE;
    repeat (8) begin step(); if (!dtack_n) ack_seen = 1; end
    sel_n = 1; uds_n = 0;
    repeat (8) begin step(); if (!dtack_n) ack_seen = 1; end
    uds_n = 1;
    repeat (4) step();
    chk(ack_seen == 0, "R3 no ack", ack_seen, 0);
    access(1, 8'd3, 8'h00, got, lat, oe_seen);
    chk(got === pat(3), "R3 unchanged", got, pat(3));

    // R9 strobe pulse released before decode
    ack_seen = 0;
    sel_n = 0; uds_n = 0; rd_wr = 0; bus_lo = 8'd4; bus_hi_i = 8'h11;
    step();
    sel_n = 1; uds_n = 1;
    repeat (8) begin step(); if (!dtack_n) ack_seen = 1; end
    chk(ack_seen == 0, "R9 no ack", ack_seen, 0);
    access(1, 8'd4, 8'h00, got, lat, oe_seen);
    chk(got === pat(4), "R9 unchanged", got, pat(4));

    // R10 combined word write
    {bus_hi_i, bus_lo} = 16'h3C07;
    access(0, 8'h07, 8'h3C, got, lat, oe_seen);
    access(1, 8'h07, 8'h00, got, lat, oe_seen);
    chk(got === 8'h3C, "R10 word write", got, 8'h3C);
    chk(bus_hi_oe === 1'b0, "R6 float after read", bus_hi_oe, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule